// File: doc/BRIEF.md
# Banking Teller Controller

This block is the control and datapath core of a small cash machine. A session opens with PIN entry from an 8-bit switch bus. After a correct PIN the block sits in a service menu, where direction buttons move a cursor over five services and the enter button opens the one under the cursor. The services are: show the balance, withdraw cash, deposit cash, deposit a check, and change the PIN.

The block holds the balance and PIN registers and applies the transaction rules. A withdrawal must be a multiple of 20, no larger than 500, and covered by the balance. No deposit may raise the balance above 1500. A new PIN must differ from the stored one. An accepted withdrawal or deposit shows the amount with a blink flag for a programmable confirmation time, about 5 s at 100 MHz. The block then shows the new balance. Errors are reported as a status code and held until the next enter press.

Buttons arrive as one-cycle pulses that are already debounced and edge-detected. The outputs are a binary display value, a status code and a blink enable, all for a separate seven-segment driver.

Top module: `teller_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the balance to 0, loads the PIN `DEFAULT_PIN` (8'h00), and enters PIN entry. In PIN entry `disp_val` is 0, `status` is 0 (OK) and `blink_en` is 0.
- R2: In PIN entry, an enter pulse with `sw` equal to the stored PIN opens the menu. Any other value sets `status` to 1 (bad PIN) and stays in PIN entry. The next enter pulse tries again, and a correct PIN clears `status` to 0.
- R3: In the menu, `disp_val` shows the cursor, starting at 0 after reset. The codes are: 0 balance, 1 withdraw, 2 cash deposit, 3 check deposit, 4 PIN change. Up or right adds 1 and down or left subtracts 1, both wrapping modulo 5. Enter opens the service under the cursor, and the cursor keeps its value on return to the menu.
- R4: Cash entry (withdraw or deposit) starts at 0 and `disp_val` shows the running total. Up adds 10, right adds 20, left adds 50 and down adds 100. In one cycle enter wins over the direction buttons, and among directions up > right > left > down. A press that would take the total above 9990 is ignored.
- R5: A withdrawal not a multiple of 20 or above 500 sets `status` 2 (bad amount) and leaves the balance unchanged. Exactly 500 is accepted.
- R6: A withdrawal that passes R5 but exceeds the balance sets `status` 3 (insufficient funds) and leaves the balance unchanged.
- R7: An accepted withdrawal or deposit updates the balance and shows the amount for `HOLD_CYCLES` cycles. The balance screen follows. On the balance screen `disp_val` is the balance, and enter returns to the menu.
- R8: During the confirmation `blink_en` is 1 for the first `HALF_CYCLES` cycles and then toggles every `HALF_CYCLES` cycles. It is 0 in every other state, and buttons are ignored during the confirmation.
- R9: A cash deposit that would raise the balance above 1500 sets `status` 4 (over limit) and leaves the balance unchanged. The next deposit entry starts again from 0. A balance of exactly 1500 is accepted.
- R10: A check deposit reads `sw[7:4]` as the tens digit and `sw[3:0]` as the units digit, in BCD. `disp_val` shows the value, or 0 when a digit is above 9. On enter, an invalid digit sets `status` 2. Otherwise the 1500 ceiling of R9 applies (`status` 4), and a valid check is accepted as in R7.
- R11: PIN change: on enter, `sw` equal to the stored PIN sets `status` 5 (same PIN) and keeps the PIN. Any other value replaces the PIN and returns to the menu with `status` 0.
- R12: An error code stays on `status` until the next enter pulse, which clears it to 0 and returns to the menu. While an error is shown, `disp_val` is 0 and direction buttons have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up | input | 1 | Up button pulse |
| btn_down | input | 1 | Down button pulse |
| btn_left | input | 1 | Left button pulse |
| btn_right | input | 1 | Right button pulse |
| btn_enter | input | 1 | Enter button pulse |
| sw | input | 8 | Switch bus: PIN or BCD check value |
| disp_val | output | 16 | Binary value for the display driver |
| status | output | 3 | 0 OK, 1 bad PIN, 2 bad amount, 3 insufficient funds, 4 over limit, 5 same PIN |
| blink_en | output | 1 | Display blink enable |

## Verification
A corrupted balance register shows up on the balance screen. It also shows up in the next withdrawal or deposit, because the insufficient-funds and over-limit decisions come one cycle after enter. A wrong stored PIN shows up at the next PIN change, which reports or misses the same-PIN error. A wrong confirmation counter changes the cycle on which `disp_val` switches from the amount to the balance, which the bench samples a few cycles on either side of. A faulty cursor or accumulator is visible on `disp_val` in the cycle after each button pulse.

// File: rtl/teller_pkg.sv
package teller_pkg;

    localparam int AMT_W = 16;

    typedef enum logic [3:0] {
        ST_PIN, ST_MENU, ST_BAL, ST_WDR, ST_DEP,
        ST_CHK, ST_NEWPIN, ST_BLINK, ST_ERR
    } state_t;

    typedef enum logic [2:0] {
        SVC_BAL = 3'd0, SVC_WDR = 3'd1, SVC_DEP = 3'd2,
        SVC_CHK = 3'd3, SVC_PIN = 3'd4
    } svc_t;

    typedef enum logic [2:0] {
        STS_OK = 3'd0, STS_BAD_PIN = 3'd1, STS_BAD_AMT = 3'd2,
        STS_NO_FUNDS = 3'd3, STS_OVER = 3'd4, STS_SAME_PIN = 3'd5
    } status_t;

    typedef enum logic [2:0] {
        INC_NONE, INC_10, INC_20, INC_50, INC_100
    } inc_t;

    typedef struct packed {
        logic up;
        logic right;
        logic left;
        logic down;
        logic enter;
    } keys_t;

    // Direction to increment, fixed priority up > right > left > down.
    function automatic inc_t pick_inc(keys_t k);
        if (k.up)         return INC_10;
        else if (k.right) return INC_20;
        else if (k.left)  return INC_50;
        else if (k.down)  return INC_100;
        else              return INC_NONE;
    endfunction

    function automatic logic [AMT_W-1:0] inc_value(inc_t i);
        case (i)
            INC_10:  return AMT_W'(10);
            INC_20:  return AMT_W'(20);
            INC_50:  return AMT_W'(50);
            INC_100: return AMT_W'(100);
            default: return '0;
        endcase
    endfunction

    function automatic logic bcd_ok(logic [7:0] s);
        return (s[7:4] <= 4'd9) && (s[3:0] <= 4'd9);
    endfunction

    function automatic logic [AMT_W-1:0] bcd_value(logic [7:0] s);
        return AMT_W'(s[7:4]) * AMT_W'(10) + AMT_W'(s[3:0]);
    endfunction

    // Cursor step with wrap over the five services.
    function automatic svc_t svc_step(svc_t s, logic fwd);
        logic [2:0] v;
        v = s;
        if (fwd) v = (v == 3'd4) ? 3'd0 : v + 3'd1;
        else     v = (v == 3'd0) ? 3'd4 : v - 3'd1;
        return svc_t'(v);
    endfunction

endpackage

// File: rtl/teller_amount.sv
module teller_amount
    import teller_pkg::*;
#(
    parameter int CAP = 9990
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  inc_t             inc,
    output logic [AMT_W-1:0] total
);
    localparam logic [AMT_W:0] CAP_V = (AMT_W+1)'(CAP);

    logic [AMT_W:0] sum;

    always_comb sum = {1'b0, total} + {1'b0, inc_value(inc)};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            total <= '0;
        end else if (inc != INC_NONE && sum <= CAP_V) begin
            total <= sum[AMT_W-1:0];
        end
    end
endmodule

// File: rtl/teller_blink.sv
module teller_blink #(
    parameter int HOLD_CYCLES = 500_000_000,
    parameter int HALF_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic phase
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam int FW = $clog2(HALF_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);
    localparam logic [FW-1:0] HALF_LAST = FW'(HALF_CYCLES - 1);

    logic [HW-1:0] cnt;
    logic [FW-1:0] hcnt;

    assign done = busy && (cnt == HOLD_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            hcnt  <= '0;
            phase <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            hcnt  <= '0;
            phase <= 1'b1;
        end else if (busy) begin
            if (done) begin
                busy  <= 1'b0;
                phase <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                if (hcnt == HALF_LAST) begin
                    hcnt  <= '0;
                    phase <= ~phase;
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/teller_ctrl.sv
module teller_ctrl
    import teller_pkg::*;
#(
    parameter int         HOLD_CYCLES = 500_000_000,
    parameter int         HALF_CYCLES = 50_000_000,
    parameter int         BAL_MAX     = 1500,
    parameter int         WDR_MAX     = 500,
    parameter int         WDR_STEP    = 20,
    parameter int         ENTRY_CAP   = 9990,
    parameter logic [7:0] DEFAULT_PIN = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        btn_up,
    input  logic        btn_down,
    input  logic        btn_left,
    input  logic        btn_right,
    input  logic        btn_enter,
    input  logic [7:0]  sw,
    output logic [15:0] disp_val,
    output logic [2:0]  status,
    output logic        blink_en
);
    localparam logic [AMT_W:0]   BAL_MAX_V  = (AMT_W+1)'(BAL_MAX);
    localparam logic [AMT_W-1:0] WDR_MAX_V  = AMT_W'(WDR_MAX);
    localparam logic [AMT_W-1:0] WDR_STEP_V = AMT_W'(WDR_STEP);

    keys_t            keys;
    state_t           state_q, state_n;
    svc_t             sel_q, sel_n;
    status_t          sts_q, sts_n;
    logic [AMT_W-1:0] bal_q, bal_n;
    logic [AMT_W-1:0] shown_q, shown_n;
    logic [7:0]       pin_q, pin_n;

    logic [AMT_W-1:0] acc;
    inc_t             acc_inc;
    logic             acc_clear;
    logic             blink_start, blink_busy, blink_done, blink_phase;

    logic [AMT_W:0]   dep_sum, chk_sum;
    logic [AMT_W-1:0] chk_val, wdr_rem;

    assign keys = '{up: btn_up, right: btn_right, left: btn_left,
                    down: btn_down, enter: btn_enter};

    teller_amount #(.CAP(ENTRY_CAP)) amount_i (
        .clk   (clk),
        .rst   (rst),
        .clear (acc_clear),
        .inc   (acc_inc),
        .total (acc)
    );

    teller_blink #(.HOLD_CYCLES(HOLD_CYCLES), .HALF_CYCLES(HALF_CYCLES)) blink_i (
        .clk   (clk),
        .rst   (rst),
        .start (blink_start),
        .busy  (blink_busy),
        .done  (blink_done),
        .phase (blink_phase)
    );

    always_comb begin
        chk_val = bcd_value(sw);
        dep_sum = {1'b0, bal_q} + {1'b0, acc};
        chk_sum = {1'b0, bal_q} + {1'b0, chk_val};
        wdr_rem = acc % WDR_STEP_V;
    end

    always_comb begin
        state_n     = state_q;
        sel_n       = sel_q;
        sts_n       = sts_q;
        bal_n       = bal_q;
        shown_n     = shown_q;
        pin_n       = pin_q;
        blink_start = 1'b0;
        acc_clear   = 1'b0;
        acc_inc     = INC_NONE;

        case (state_q)
            ST_PIN: begin
                if (keys.enter) begin
                    if (sw == pin_q) begin
                        state_n = ST_MENU;
                        sts_n   = STS_OK;
                    end else begin
                        sts_n = STS_BAD_PIN;
                    end
                end
            end
            ST_MENU: begin
                if (keys.enter) begin
                    acc_clear = 1'b1;
                    case (sel_q)
                        SVC_BAL: state_n = ST_BAL;
                        SVC_WDR: state_n = ST_WDR;
                        SVC_DEP: state_n = ST_DEP;
                        SVC_CHK: state_n = ST_CHK;
                        default: state_n = ST_NEWPIN;
                    endcase
                end else if (keys.up || keys.right) begin
                    sel_n = svc_step(sel_q, 1'b1);
                end else if (keys.down || keys.left) begin
                    sel_n = svc_step(sel_q, 1'b0);
                end
            end
            ST_BAL: begin
                if (keys.enter) state_n = ST_MENU;
            end
            ST_WDR: begin
                if (keys.enter) begin
                    if (wdr_rem != '0 || acc > WDR_MAX_V) begin
                        state_n = ST_ERR;
                        sts_n   = STS_BAD_AMT;
                    end else if (acc > bal_q) begin
                        state_n = ST_ERR;
                        sts_n   = STS_NO_FUNDS;
                    end else begin
                        bal_n       = bal_q - acc;
                        shown_n     = acc;
                        state_n     = ST_BLINK;
                        blink_start = 1'b1;
                    end
                end else begin
                    acc_inc = pick_inc(keys);
                end
            end
            ST_DEP: begin
                if (keys.enter) begin
                    if (dep_sum > BAL_MAX_V) begin
                        state_n = ST_ERR;
                        sts_n   = STS_OVER;
                    end else begin
                        bal_n       = dep_sum[AMT_W-1:0];
                        shown_n     = acc;
                        state_n     = ST_BLINK;
                        blink_start = 1'b1;
                    end
                end else begin
                    acc_inc = pick_inc(keys);
                end
            end
            ST_CHK: begin
                if (keys.enter) begin
                    if (!bcd_ok(sw)) begin
                        state_n = ST_ERR;
                        sts_n   = STS_BAD_AMT;
                    end else if (chk_sum > BAL_MAX_V) begin
                        state_n = ST_ERR;
                        sts_n   = STS_OVER;
                    end else begin
                        bal_n       = chk_sum[AMT_W-1:0];
                        shown_n     = chk_val;
                        state_n     = ST_BLINK;
                        blink_start = 1'b1;
                    end
                end
            end
            ST_NEWPIN: begin
                if (keys.enter) begin
                    if (sw == pin_q) begin
                        state_n = ST_ERR;
                        sts_n   = STS_SAME_PIN;
                    end else begin
                        pin_n   = sw;
                        state_n = ST_MENU;
                    end
                end
            end
            ST_BLINK: begin
                if (blink_done) state_n = ST_BAL;
            end
            ST_ERR: begin
                if (keys.enter) begin
                    state_n = ST_MENU;
                    sts_n   = STS_OK;
                end
            end
            default: state_n = ST_PIN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PIN;
            sel_q   <= SVC_BAL;
            sts_q   <= STS_OK;
            bal_q   <= '0;
            shown_q <= '0;
            pin_q   <= DEFAULT_PIN;
        end else begin
            state_q <= state_n;
            sel_q   <= sel_n;
            sts_q   <= sts_n;
            bal_q   <= bal_n;
            shown_q <= shown_n;
            pin_q   <= pin_n;
        end
    end

    always_comb begin
        case (state_q)
            ST_MENU:        disp_val = 16'(sel_q);
            ST_BAL:         disp_val = bal_q;
            ST_WDR, ST_DEP: disp_val = acc;
            ST_CHK:         disp_val = bcd_ok(sw) ? chk_val : '0;
            ST_NEWPIN:      disp_val = 16'(sw);
            ST_BLINK:       disp_val = shown_q;
            default:        disp_val = '0;
        endcase
    end

    assign status   = sts_q;
    assign blink_en = (state_q == ST_BLINK) && blink_phase && blink_busy;

endmodule

// File: rtl/teller_ctrl_chk.sv
module teller_ctrl_chk
    import teller_pkg::*;
#(
    parameter int         BAL_MAX     = 1500,
    parameter int         WDR_MAX     = 500,
    parameter int         WDR_STEP    = 20,
    parameter logic [7:0] DEFAULT_PIN = 8'h00
) (
    input logic        clk,
    input logic        rst,
    input logic        enter,
    input state_t      state_q,
    input logic [15:0] bal,
    input logic [7:0]  pin,
    input logic [2:0]  status,
    input logic        blink_en
);
    logic        seen_rst;
    logic [15:0] prev_bal;
    logic [15:0] drop;

    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
        prev_bal <= bal;
    end

    always_comb drop = prev_bal - bal;

    AST_RESET_VALUES: assert property (@(posedge clk)
        (seen_rst && $past(rst)) |-> (bal == 16'd0 && pin == DEFAULT_PIN && status == 3'd0 && !blink_en)); // R1

    AST_BAL_CEILING: assert property (@(posedge clk) disable iff (rst)
        bal <= 16'(BAL_MAX)); // R9

    AST_BAL_ON_ENTER: assert property (@(posedge clk) disable iff (rst)
        !$past(enter) |-> $stable(bal)); // R7

    AST_WDR_RULE: assert property (@(posedge clk) disable iff (rst)
        (bal < prev_bal) |-> ((drop % 16'(WDR_STEP)) == 16'd0 && drop <= 16'(WDR_MAX))); // R5

    AST_PIN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (pin != $past(pin)) |-> ($past(enter) && $past(state_q) == ST_NEWPIN)); // R11

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(status) != 3'd0 && !$past(enter)) |-> $stable(status)); // R12

    AST_BLINK_OK: assert property (@(posedge clk) disable iff (rst)
        blink_en |-> status == 3'd0); // R8

endmodule

bind teller_ctrl teller_ctrl_chk #(
    .BAL_MAX(BAL_MAX), .WDR_MAX(WDR_MAX), .WDR_STEP(WDR_STEP), .DEFAULT_PIN(DEFAULT_PIN)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .enter    (btn_enter),
    .state_q  (state_q),
    .bal      (bal_q),
    .pin      (pin_q),
    .status   (status),
    .blink_en (blink_en)
);

// File: tb/teller_ctrl_tb_top.sv
module teller_ctrl_tb_top;

    localparam int HOLD = 40;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        btn_up = 1'b0, btn_down = 1'b0, btn_left = 1'b0;
    logic        btn_right = 1'b0, btn_enter = 1'b0;
    logic [7:0]  sw = 8'h00;
    logic [15:0] disp_val;
    logic [2:0]  status;
    logic        blink_en;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_bal = 0;
    int exp_sel = 0;

    always #10 clk = ~clk;

    teller_ctrl #(.HOLD_CYCLES(HOLD), .HALF_CYCLES(HALF)) dut_i (
        .clk(clk), .rst(rst), .btn_up(btn_up), .btn_down(btn_down),
        .btn_left(btn_left), .btn_right(btn_right), .btn_enter(btn_enter),
        .sw(sw), .disp_val(disp_val), .status(status), .blink_en(blink_en)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // mask bits: 0 up, 1 right, 2 left, 3 down, 4 enter
    task automatic press(logic [4:0] m);
        btn_up = m[0]; btn_right = m[1]; btn_left = m[2];
        btn_down = m[3]; btn_enter = m[4];
        tick();
        btn_up = 0; btn_right = 0; btn_left = 0; btn_down = 0; btn_enter = 0;
    endtask

    task automatic enter();
        press(5'b10000);
    endtask

    function automatic int inc_of(int idx);
        case (idx)
            0: return 10;
            1: return 20;
            2: return 50;
            default: return 100;
        endcase
    endfunction

    function automatic int wdr_status(int amt, int bal);
        if ((amt % 20) != 0 || amt > 500) return 2;
        if (amt > bal) return 3;
        return 0;
    endfunction

    function automatic int dep_status(int amt, int bal);
        return (bal + amt > 1500) ? 4 : 0;
    endfunction

    // Move the cursor up to a service, check it, open it.
    task automatic open_svc(int svc);
        for (int i = 0; i < 5 && exp_sel != svc; i++) begin
            press(5'b00001);
            exp_sel = (exp_sel + 1) % 5;
        end
        check("R3 cursor", disp_val, svc);
        enter();
    endtask

    task automatic wait_confirm_and_check(string req);
        repeat (HOLD + 3) tick();
        check(req, disp_val, exp_bal);
        check(req, blink_en, 0);
        enter();
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) tick();
        rst = 0;
        tick();

        // R1 reset state
        check("R1 disp", disp_val, 0);
        check("R1 status", status, 0);
        check("R1 blink", blink_en, 0);

        // R2 PIN entry
        sw = 8'h5A; enter();
        check("R2 bad pin", status, 1);
        press(5'b00001);
        check("R2 still pin entry", disp_val, 0);
        sw = 8'h00; enter();
        check("R2 good pin", status, 0);

        // R3 navigation
        press(5'b00001); check("R3 up", disp_val, 1);
        press(5'b01000); check("R3 down", disp_val, 0);
        press(5'b00100); check("R3 left wrap", disp_val, 4);
        press(5'b00010); check("R3 right wrap", disp_val, 0);
        exp_sel = 0;

        // R13-ish balance screen (R7)
        open_svc(0);
        check("R7 balance screen", disp_val, 0);
        enter();

        // R4 accumulation and priority
        open_svc(2);
        check("R4 start zero", disp_val, 0);
        press(5'b00001); check("R4 up10", disp_val, 10);
        press(5'b00010); check("R4 right20", disp_val, 30);
        press(5'b00100); check("R4 left50", disp_val, 80);
        press(5'b01000); check("R4 down100", disp_val, 180);
        press(5'b01001); check("R4 priority up", disp_val, 190);
        enter();
        exp_bal = 190;
        check("R7 shows amount", disp_val, 190);
        check("R8 blink first half", blink_en, 1);
        repeat (5) tick();
        check("R8 blink toggled", blink_en, 0);
        press(5'b00001);
        check("R8 button ignored", disp_val, 190);
        repeat (4) tick();
        check("R8 blink back on", blink_en, 1);
        wait_confirm_and_check("R7 balance after deposit");

        // R5 invalid withdrawals
        open_svc(1);
        press(5'b00001); press(5'b00010);
        enter();
        check("R5 not multiple of 20", status, 2);
        press(5'b00001);
        check("R12 held", status, 2);
        check("R12 disp zero", disp_val, 0);
        enter();
        check("R12 cleared", status, 0);
        check("R12 back to menu", disp_val, 1);
        enter();
        for (int i = 0; i < 5; i++) press(5'b01000);
        press(5'b00010);
        enter();
        check("R5 above 500", status, 2);
        enter();

        // R6 insufficient funds
        enter();
        press(5'b01000); press(5'b01000);
        enter();
        check("R6 no funds", status, 3);
        repeat (3) tick();
        check("R12 hold over time", status, 3);
        enter();

        // R7 valid withdrawal with timing
        enter();
        press(5'b00010); press(5'b00010);
        enter();
        exp_bal = 150;
        repeat (HOLD - 3) tick();
        check("R7 still confirming", disp_val, 40);
        repeat (6) tick();
        check("R7 balance after withdraw", disp_val, 150);
        enter();

        // R9 over limit and boundary
        open_svc(2);
        for (int i = 0; i < 14; i++) press(5'b01000);
        check("R4 1400", disp_val, 1400);
        enter();
        check("R9 over limit", status, 4);
        enter();
        enter();
        check("R9 entry restarts", disp_val, 0);
        for (int i = 0; i < 13; i++) press(5'b01000);
        press(5'b00100);
        enter();
        check("R9 exact ceiling", status, 0);
        exp_bal = 1500;
        wait_confirm_and_check("R9 balance 1500");

        // R10 check deposit
        open_svc(3);
        sw = 8'h01; tick();
        check("R10 disp", disp_val, 1);
        enter();
        check("R10 ceiling", status, 4);
        enter();
        enter();
        sw = 8'h1A; tick();
        check("R10 invalid disp", disp_val, 0);
        enter();
        check("R10 invalid digit", status, 2);
        enter();
        open_svc(1);
        for (int i = 0; i < 5; i++) press(5'b01000);
        enter();
        check("R5 exactly 500", status, 0);
        exp_bal = 1000;
        wait_confirm_and_check("R5 balance after 500");
        open_svc(3);
        sw = 8'h42; tick();
        check("R10 value 42", disp_val, 42);
        enter();
        exp_bal = 1042;
        check("R10 confirm", disp_val, 42);
        wait_confirm_and_check("R10 balance");

        // R11 PIN change
        open_svc(4);
        sw = 8'h00; tick();
        enter();
        check("R11 same pin", status, 5);
        enter();
        enter();
        sw = 8'h3C; enter();
        check("R11 accepted", status, 0);
        check("R11 menu", disp_val, 4);
        enter();
        enter();
        check("R11 new pin stored", status, 5);
        enter();

        // Random cash transactions
        for (int t = 0; t < 24; t++) begin
            int is_dep, n, amt, st;
            is_dep = int'($urandom_range(0, 1));
            n = int'($urandom_range(0, 6));
            amt = 0;
            open_svc(is_dep ? 2 : 1);
            for (int k = 0; k < n; k++) begin
                int d;
                d = int'($urandom_range(0, 3));
                press(5'(1 << d));
                amt += inc_of(d);
            end
            check("R4 random total", disp_val, amt);
            st = is_dep ? dep_status(amt, exp_bal) : wdr_status(amt, exp_bal);
            enter();
            check(is_dep ? "R9 random status" : "R5 R6 random status", status, st);
            if (st == 0) begin
                exp_bal = is_dep ? exp_bal + amt : exp_bal - amt;
                wait_confirm_and_check("R7 random balance");
            end else begin
                enter();
            end
        end
        open_svc(0);
        check("R7 final balance", disp_val, exp_bal);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule